// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block turns one 128-bit plaintext block into its AES-128 ciphertext under a 128-bit cipher key. Rather than laying out ten copies of the round logic, it keeps a single round datapath. A small sequencer steps that datapath through the rounds, and the state is registered between passes. Each round key is derived from the previous one in the same cycle that consumes it, so the core stores no expanded key schedule.

A request is a one-cycle `start_i` pulse with `plain_i` and `key_i` valid. On the capture edge the core XORs the key into the plaintext and registers the result. It then spends one clock on each of the nine full rounds and one clock on the reduced final round. The ciphertext appears on `cipher_o` together with a one-cycle `done_o` pulse. The result stays on `cipher_o` until the next block completes.

Top module: `aes_iter_enc`

## Requirements
- R1: While reset (`rst_i`, active high) is applied and right after it is released, `done_o` is 0 and `cipher_o` is all zeros.
- R2: Bytes map most-significant first. Byte 0 is bits 127:120 and byte k is bits 127-8k down to 120-8k. Byte k sits at row k mod 4, column k div 4 of the state, and the output is read back in the same order. Plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: Plaintext 3243f6a8885a308d313198a2e0370734 under key 2b7e151628aed2a6abf7158809cf4f3c gives 3925841d02dc09fbdc118597196a0b32.
- R4: An all-zero plaintext under an all-zero key gives 66e94bd4ef8a2c3b884cfa59ca342b2e. This exercises the S-box entry for 00 and the round constants with no key bits set.
- R5: Suppose `start_i` is sampled high by an idle core at clock edge N. Then `done_o` is high after edge N+10 for exactly one cycle.
- R6: A `start_i` pulse that arrives while a block is in flight is ignored. The in-flight result is unchanged, and no extra `done_o` pulse is produced.
- R7: `cipher_o` changes only on the edge that raises `done_o`, and holds its value between completions.
- R8: A new `start_i` may be applied in the cycle in which `done_o` is high. That block is accepted with the same latency as R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to encrypt the block on plain_i with key_i |
| plain_i | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| key_i | input | 128 | Cipher key, byte 0 in bits 127:120 |
| cipher_o | output | 128 | Ciphertext of the most recently completed block |
| done_o | output | 1 | One-cycle pulse marking a new value on cipher_o |

## Verification
The core is driven with three fixed vectors that separate different faults. A distinct-byte plaintext under a counting key exposes any byte-order, ShiftRows or MixColumns coefficient error. A second key and plaintext pair catches round-constant and key-schedule faults that the counting key might hide. The all-zero vector isolates the S-box entry for zero and the case where the final round wrongly keeps MixColumns. A stray start in mid-block and a start issued on the done cycle then show whether the sequencer ignores requests while busy and accepts them exactly when it falls idle.

// File: rtl/aes_it_pkg.sv
package aes_it_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_BYTES  = 16;
    localparam int BLK_W      = BYTE_W * NUM_BYTES;
    localparam int NUM_ROUNDS = 10;
    localparam int RND_W      = 4;
    localparam int ROM_DEPTH  = 1 << BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BLK_W-1:0]  block_t;
    typedef byte_t             sbox_tbl_t [ROM_DEPTH];

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic byte_t xtime(byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // inverse as x^254, then the affine map
    function automatic byte_t sbox_calc(byte_t x);
        byte_t sq  = x;
        byte_t inv = 8'h01;
        for (int i = 0; i < 7; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

    function automatic sbox_tbl_t build_sbox();
        sbox_tbl_t t;
        for (int i = 0; i < ROM_DEPTH; i++) t[i] = sbox_calc(byte_t'(i));
        return t;
    endfunction

endpackage

// File: rtl/aes_sbox_rom.sv
module aes_sbox_rom
    import aes_it_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_i,
    output logic [BYTE_W-1:0] data_o
);
    localparam int NIB_W = BYTE_W / 2;
    localparam sbox_tbl_t ROM = build_sbox();

    logic [NIB_W-1:0] row_sel;
    logic [NIB_W-1:0] col_sel;

    assign row_sel = addr_i[BYTE_W-1:NIB_W];
    assign col_sel = addr_i[NIB_W-1:0];
    assign data_o  = ROM[{row_sel, col_sel}];
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_it_pkg::*;
(
    input  logic [BLK_W-1:0]  key_i,
    input  logic [BYTE_W-1:0] rcon_i,
    output logic [BLK_W-1:0]  key_o
);
    localparam int WORD_W = 4 * BYTE_W;
    localparam int NWORDS = BLK_W / WORD_W;

    logic [WORD_W-1:0] w_in  [NWORDS];
    logic [WORD_W-1:0] w_out [NWORDS];
    logic [WORD_W-1:0] rot_w;
    logic [WORD_W-1:0] sub_w;
    logic [WORD_W-1:0] mix_w;

    for (genvar k = 0; k < NWORDS; k++) begin : g_split
        assign w_in[k] = key_i[BLK_W-1-WORD_W*k -: WORD_W];
        assign key_o[BLK_W-1-WORD_W*k -: WORD_W] = w_out[k];
    end

    assign rot_w = {w_in[NWORDS-1][WORD_W-BYTE_W-1:0], w_in[NWORDS-1][WORD_W-1 -: BYTE_W]};

    for (genvar b = 0; b < 4; b++) begin : g_subw
        aes_sbox_rom u_rom (
            .addr_i (rot_w[WORD_W-1-BYTE_W*b -: BYTE_W]),
            .data_o (sub_w[WORD_W-1-BYTE_W*b -: BYTE_W])
        );
    end

    assign mix_w = sub_w ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};

    always_comb begin
        w_out[0] = w_in[0] ^ mix_w;
        for (int k = 1; k < NWORDS; k++) w_out[k] = w_in[k] ^ w_out[k-1];
    end
endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_it_pkg::*;
(
    input  logic [BLK_W-1:0] state_i,
    input  logic [BLK_W-1:0] rkey_i,
    input  logic             last_i,
    output logic [BLK_W-1:0] state_o
);
    localparam int NROW = 4;
    localparam int NCOL = NUM_BYTES / NROW;

    byte_t sb [NUM_BYTES];
    byte_t sr [NUM_BYTES];
    byte_t mc [NUM_BYTES];

    // sub-bytes: one ROM per state byte
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sub
        aes_sbox_rom u_rom (
            .addr_i (state_i[BLK_W-1-BYTE_W*i -: BYTE_W]),
            .data_o (sb[i])
        );
    end

    // shift-rows: row r rotated left by r columns
    for (genvar r = 0; r < NROW; r++) begin : g_row
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            assign sr[r + NROW*c] = sb[r + NROW*((c + r) % NCOL)];
        end
    end

    // mix-columns with coefficients 02,03,01,01 rotated per row
    for (genvar c = 0; c < NCOL; c++) begin : g_mix
        always_comb begin
            for (int r = 0; r < NROW; r++) begin
                mc[NROW*c + r] = xtime(sr[NROW*c + r])
                               ^ xtime(sr[NROW*c + (r+1)%NROW]) ^ sr[NROW*c + (r+1)%NROW]
                               ^ sr[NROW*c + (r+2)%NROW]
                               ^ sr[NROW*c + (r+3)%NROW];
            end
        end
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_ark
        assign state_o[BLK_W-1-BYTE_W*i -: BYTE_W] =
            (last_i ? sr[i] : mc[i]) ^ rkey_i[BLK_W-1-BYTE_W*i -: BYTE_W];
    end
endmodule

// File: rtl/aes_iter_enc.sv
module aes_iter_enc
    import aes_it_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [127:0]     plain_i,
    input  logic [127:0]     key_i,
    output logic [127:0]     cipher_o,
    output logic             done_o
);
    localparam logic [RND_W-1:0]  LAST_RND  = RND_W'(NUM_ROUNDS);
    localparam logic [BYTE_W-1:0] RCON_INIT = 8'h01;

    typedef struct packed {
        logic              busy;
        logic [RND_W-1:0]  rnd;
        logic [BLK_W-1:0]  st;
        logic [BLK_W-1:0]  rk;
        logic [BYTE_W-1:0] rcon;
        logic              done;
        logic [BLK_W-1:0]  ct;
    } regs_t;

    regs_t r_q, r_d;

    logic [BLK_W-1:0] next_key;
    logic [BLK_W-1:0] round_out;
    logic             is_last;

    assign is_last = (r_q.rnd == LAST_RND);

    aes_key_step u_key (
        .key_i  (r_q.rk),
        .rcon_i (r_q.rcon),
        .key_o  (next_key)
    );

    aes_round u_round (
        .state_i (r_q.st),
        .rkey_i  (next_key),
        .last_i  (is_last),
        .state_o (round_out)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start_i) begin
                r_d.busy = 1'b1;
                r_d.rnd  = RND_W'(1);
                r_d.st   = plain_i ^ key_i;
                r_d.rk   = key_i;
                r_d.rcon = RCON_INIT;
            end
        end else begin
            r_d.st   = round_out;
            r_d.rk   = next_key;
            r_d.rcon = xtime(r_q.rcon);
            if (is_last) begin
                r_d.busy = 1'b0;
                r_d.rnd  = '0;
                r_d.done = 1'b1;
                r_d.ct   = round_out;
            end else begin
                r_d.rnd  = r_q.rnd + RND_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign cipher_o = r_q.ct;
    assign done_o   = r_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);                                          // R5
    AST_LAST_GIVES_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.busy && is_last) |=> done_o);                            // R5
    AST_ROUND_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        r_q.rnd <= LAST_RND);                                         // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.busy && !is_last) |=> (r_q.busy && r_q.rnd == $past(r_q.rnd) + RND_W'(1))); // R6
    AST_CT_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_o |-> $stable(cipher_o));                               // R7
    AST_IDLE_START: assert property (@(posedge clk_i) disable iff (rst_i)
        (!r_q.busy && start_i) |=> (r_q.busy && r_q.rnd == RND_W'(1))); // R8
endmodule

// File: tb/aes_iter_enc_tb.sv
module aes_iter_enc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 11;
    localparam int WDOG_LIMIT = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] plain = '0;
    logic [127:0] key = '0;
    logic [127:0] cipher;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_done   = 0;
    logic prev_done = 1'b0;
    logic finished  = 1'b0;

    logic [127:0] exp_q [$];
    int           stc_q [$];
    string        tag_q [$];

    aes_iter_enc dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .plain_i  (plain),
        .key_i    (key),
        .cipher_o (cipher),
        .done_o   (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // driver: issue a block at the current negedge, push the expectation
    task automatic issue(input logic [127:0] p, input logic [127:0] k,
                         input logic [127:0] e, input string req);
        plain = p;
        key   = k;
        start = 1'b1;
        exp_q.push_back(e);
        stc_q.push_back(cyc);
        tag_q.push_back(req);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                n_done++;
                check(!prev_done, "R5 done wider than one cycle", {127'd0, prev_done}, 128'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", cipher, 128'd0);
                end else begin
                    logic [127:0] e;
                    int           s;
                    string        t;
                    e = exp_q.pop_front();
                    s = stc_q.pop_front();
                    t = tag_q.pop_front();
                    check(cipher === e, t, cipher, e);
                    check(cyc - s == LATENCY, "R5 latency", 128'(cyc - s), 128'(LATENCY));
                end
            end
            prev_done = done;
        end
    end

    initial begin : watchdog
        repeat (WDOG_LIMIT) @(posedge clk);
        check(1'b0, "watchdog expired", 128'd0, 128'd0);
        summary();
    end

    localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
    localparam logic [127:0] C3 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0, "R1 done in reset", {127'd0, done}, 128'd0);
        check(cipher === '0, "R1 cipher in reset", cipher, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R1 done after reset", {127'd0, done}, 128'd0);
        check(cipher === '0, "R1 cipher after reset", cipher, 128'd0);

        // R2 byte order and main vector
        issue(P1, K1, C1, "R2 vector");
        wait_done();
        @(negedge clk);

        // R3 second key
        issue(P2, K2, C2, "R3 vector");
        wait_done();
        @(negedge clk);

        // R7 ciphertext holds between completions
        repeat (5) @(negedge clk);
        check(cipher === C2, "R7 hold", cipher, C2);

        // R4 all-zero
        issue('0, '0, C3, "R4 vector");
        wait_done();
        @(negedge clk);

        // R6 stray start mid-block with different data
        issue(P1, K1, C1, "R6 in-flight result");
        repeat (3) @(negedge clk);
        plain = ~P2;
        key   = ~K2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        repeat (15) @(negedge clk);
        check(exp_q.size() == 0, "R6 pending items", 128'(exp_q.size()), 128'd0);
        check(cipher === C1, "R6 result untouched", cipher, C1);

        // R8 start on the done cycle
        issue(P2, K2, C2, "R8 first");
        wait_done();
        issue('0, '0, C3, "R8 back-to-back");
        wait_done();
        @(negedge clk);
        repeat (3) @(negedge clk);

        check(n_done == 6, "R6 done pulse count", 128'(n_done), 128'd6);
        check(exp_q.size() == 0, "R8 all results seen", 128'(exp_q.size()), 128'd0);
        summary();
    end
endmodule